// File: doc/BRIEF.md
# Program Counter Sequencer with Circular Return Stack

This block produces the instruction fetch address of a small accumulator-style processor core. It keeps a 13-bit address register that can reach 8K words of program memory, split into four 2K-word pages starting at 0x0000, 0x0800, 0x1000 and 0x1800. Each cycle the decoded control strobes pick how the address moves on. It can step to the next word, branch to a page-relative literal, branch and save a return point, restore the saved return point, take a new low byte from the ALU, or be forced to the interrupt vector.

The upper address bits never come from the instruction. They come from a 5-bit page register that software writes through its own port. An eight-entry circular return stack stores full 13-bit return addresses. It has no overflow or underflow indication. Extra saves overwrite the oldest entry, and extra restores wrap around the ring.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low and after its release, `fetch_addr` is 0x0000, the page register is 0 and every stack slot holds 0x0000.
- R2: A cycle with only `op_step` set loads `fetch_addr + 1` at the next clock edge. The addition is modulo 2^13, so 0x1FFF is followed by 0x0000.
- R3: A cycle whose winning strobe is `op_jump` loads `{page[4:3], jmp_lit[10:0]}` and leaves the stack untouched.
- R4: A cycle whose winning strobe is `op_call` loads the same target as R3 and saves `fetch_addr + 1` on the stack.
- R5: A cycle whose winning strobe is `op_ret` loads the most recently saved stack value that has not yet been restored (last in, first out).
- R6: A cycle whose winning strobe is `alu_wr_en` loads `{page[4:0], alu_data[7:0]}`.
- R7: A cycle with `irq_take` set loads 0x0004 and saves `fetch_addr + 1`. The page register keeps its value even if `page_we` is set in that same cycle.
- R8: The stack is a ring of eight slots. A ninth unrestored save overwrites the oldest entry. A restore with nothing outstanding returns the slot the ring pointer wraps back to, and raises no flag.
- R9: When several strobes are set, only one acts. The order is `irq_take`, then `op_ret`, then `op_call`, then `op_jump`, then `alu_wr_en`, then `op_step`. With none set, `fetch_addr` holds its value.
- R10: `page_we` loads `page_din` at the clock edge. A jump, call or ALU write in the same cycle still uses the old page value. Later cycles use the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_take | input | 1 | Interrupt accepted: go to the vector and save the return point |
| op_step | input | 1 | Advance to the next sequential word |
| op_jump | input | 1 | Branch to a page-relative literal |
| op_call | input | 1 | Branch to a literal and save the return point |
| op_ret | input | 1 | Restore the most recent return point (any return flavour) |
| alu_wr_en | input | 1 | ALU writes the low address byte |
| alu_data | input | 8 | ALU result used by `alu_wr_en` |
| jmp_lit | input | 11 | Branch literal from the instruction |
| page_we | input | 1 | Write strobe for the page register |
| page_din | input | 5 | New page register value |
| fetch_addr | output | 13 | Current fetch address |

## Verification
The bench builds the block with its default parameters: a 13-bit address, an 11-bit literal, an 8-bit ALU byte and an eight-slot stack. With these values every page boundary is reachable. The top address 0x1FFF is reached by an ALU write with page 0x1F, which makes the modulo wrap observable. Nine nested calls are enough to overwrite the oldest stack slot, and the following restores walk past the empty point. Directed priority collisions and a long pseudo-random strobe sequence are compared on every clock against a behavioural model.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Action chosen for the program counter in one cycle.
  typedef enum logic [2:0] {
    SEL_HOLD = 3'd0,
    SEL_STEP = 3'd1,
    SEL_ALU  = 3'd2,
    SEL_JUMP = 3'd3,
    SEL_CALL = 3'd4,
    SEL_RET  = 3'd5,
    SEL_IRQ  = 3'd6
  } pc_sel_e;

  function automatic logic sel_pushes(pc_sel_e s);
    return (s == SEL_CALL) || (s == SEL_IRQ);
  endfunction

  function automatic logic sel_pops(pc_sel_e s);
    return (s == SEL_RET);
  endfunction

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
(
  input  logic    irq_take,
  input  logic    op_step,
  input  logic    op_jump,
  input  logic    op_call,
  input  logic    op_ret,
  input  logic    alu_wr_en,
  output pc_sel_e sel
);

  // Fixed priority: interrupt wins, plain step loses.
  always_comb begin
    if (irq_take)       sel = SEL_IRQ;
    else if (op_ret)    sel = SEL_RET;
    else if (op_call)   sel = SEL_CALL;
    else if (op_jump)   sel = SEL_JUMP;
    else if (alu_wr_en) sel = SEL_ALU;
    else if (op_step)   sel = SEL_STEP;
    else                sel = SEL_HOLD;
  end

endmodule

// File: rtl/pcs_page_reg.sv
module pcs_page_reg #(
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_we,
  input  logic              irq_take,
  input  logic [PAGE_W-1:0] page_din,
  output logic [PAGE_W-1:0] page_q
);

  logic              page_en;
  logic [PAGE_W-1:0] page_d;

  // An accepted interrupt blocks a write in the same cycle.
  always_comb begin
    page_en = page_we && !irq_take;
    page_d  = page_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_en) page_q <= page_d;
  end

  assert_page_kept_on_irq_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    irq_take |=> $stable(page_q)
  );

  assert_page_write_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    (page_we && !irq_take) |=> (page_q == $past(page_din))
  );

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top_val
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr;
  logic [W-1:0]     slot_q [DEPTH];
  logic [DEPTH-1:0] slot_en;

  // The pointer names the next free slot; the top entry sits one below it.
  always_comb begin
    rd_ptr = wr_ptr_q - PTR_W'(1);
    if (push)     wr_ptr_d = wr_ptr_q + PTR_W'(1);
    else if (pop) wr_ptr_d = rd_ptr;
    else          wr_ptr_d = wr_ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wr_ptr_q <= '0;
    else if (push || pop)  wr_ptr_q <= wr_ptr_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb slot_en[i] = push && (wr_ptr_q == PTR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[i] <= '0;
      else if (slot_en[i]) slot_q[i] <= push_val;
    end
  end

  always_comb top_val = slot_q[rd_ptr];

  initial begin
    assert_depth_pow2_R8: assert ((DEPTH & (DEPTH - 1)) == 0);
  end

  assert_single_op_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    !(push && pop)
  );

  assert_push_advances_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    push |=> (wr_ptr_q == $past(wr_ptr_q) + PTR_W'(1))
  );

  assert_pop_returns_saved_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    push |=> (top_val == $past(push_val))
  );

endmodule

// File: rtl/pcs_next_addr.sv
module pcs_next_addr
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LIT_W  = 11,
  parameter int ALU_W  = 8,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 13'h0004
) (
  input  pc_sel_e                  sel,
  input  logic [ADDR_W-1:0]        cur_addr,
  input  logic [ADDR_W-ALU_W-1:0]  page,
  input  logic [LIT_W-1:0]         lit,
  input  logic [ALU_W-1:0]         alu_byte,
  input  logic [ADDR_W-1:0]        stack_top,
  output logic [ADDR_W-1:0]        seq_addr,
  output logic [ADDR_W-1:0]        next_addr
);

  localparam int PAGE_W = ADDR_W - ALU_W;
  localparam int HI_W   = ADDR_W - LIT_W;

  logic [ADDR_W-1:0] branch_addr;
  logic [ADDR_W-1:0] alu_addr;

  always_comb begin
    seq_addr    = cur_addr + ADDR_W'(1);
    branch_addr = {page[PAGE_W-1 -: HI_W], lit};
    alu_addr    = {page, alu_byte};
    unique case (sel)
      SEL_STEP: next_addr = seq_addr;
      SEL_ALU:  next_addr = alu_addr;
      SEL_JUMP,
      SEL_CALL: next_addr = branch_addr;
      SEL_RET:  next_addr = stack_top;
      SEL_IRQ:  next_addr = IRQ_VEC;
      default:  next_addr = cur_addr;
    endcase
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int LIT_W       = 11,
  parameter int ALU_W       = 8,
  parameter int STACK_DEPTH = 8,
  parameter logic [ADDR_W-1:0] RESET_VEC = 13'h0000,
  parameter logic [ADDR_W-1:0] IRQ_VEC   = 13'h0004
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     irq_take,
  input  logic                     op_step,
  input  logic                     op_jump,
  input  logic                     op_call,
  input  logic                     op_ret,
  input  logic                     alu_wr_en,
  input  logic [ALU_W-1:0]         alu_data,
  input  logic [LIT_W-1:0]         jmp_lit,
  input  logic                     page_we,
  input  logic [ADDR_W-ALU_W-1:0]  page_din,
  output logic [ADDR_W-1:0]        fetch_addr
);

  localparam int PAGE_W = ADDR_W - ALU_W;

  pc_sel_e            sel;
  logic [PAGE_W-1:0]  page_q;
  logic [ADDR_W-1:0]  pc_q, pc_d, seq_addr, stack_top;
  logic               push, pop, pc_en;

  pcs_decode u_decode (
    .irq_take  (irq_take),
    .op_step   (op_step),
    .op_jump   (op_jump),
    .op_call   (op_call),
    .op_ret    (op_ret),
    .alu_wr_en (alu_wr_en),
    .sel       (sel)
  );

  pcs_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk      (clk),
    .rst_n    (rst_n),
    .page_we  (page_we),
    .irq_take (irq_take),
    .page_din (page_din),
    .page_q   (page_q)
  );

  pcs_next_addr #(
    .ADDR_W (ADDR_W),
    .LIT_W  (LIT_W),
    .ALU_W  (ALU_W),
    .IRQ_VEC(IRQ_VEC)
  ) u_next (
    .sel       (sel),
    .cur_addr  (pc_q),
    .page      (page_q),
    .lit       (jmp_lit),
    .alu_byte  (alu_data),
    .stack_top (stack_top),
    .seq_addr  (seq_addr),
    .next_addr (pc_d)
  );

  always_comb begin
    push  = sel_pushes(sel);
    pop   = sel_pops(sel);
    pc_en = (sel != SEL_HOLD);
  end

  pcs_ret_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .push_val (seq_addr),
    .top_val  (stack_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_VEC;
    else if (pc_en) pc_q <= pc_d;
  end

  always_comb fetch_addr = pc_q;

  assert_irq_vector_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    irq_take |=> (fetch_addr == IRQ_VEC)
  );

  assert_step_inc_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (op_step && !irq_take && !op_ret && !op_call && !op_jump && !alu_wr_en)
      |=> (fetch_addr == $past(fetch_addr) + ADDR_W'(1))
  );

  assert_idle_hold_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    (!op_step && !irq_take && !op_ret && !op_call && !op_jump && !alu_wr_en)
      |=> $stable(fetch_addr)
  );

  assert_call_literal_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (op_call && !irq_take && !op_ret)
      |=> (fetch_addr[LIT_W-1:0] == $past(jmp_lit))
  );

  assert_alu_low_byte_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (alu_wr_en && !irq_take && !op_ret && !op_call && !op_jump)
      |=> (fetch_addr[ALU_W-1:0] == $past(alu_data))
  );

endmodule

// File: tb/pc_sequencer_tb.sv
`timescale 1ns/1ps
module pc_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_take, op_step, op_jump, op_call, op_ret, alu_wr_en, page_we;
  logic [7:0]  alu_data;
  logic [10:0] jmp_lit;
  logic [4:0]  page_din;
  logic [12:0] fetch_addr;

  int total = 0;
  int bad   = 0;

  // Behavioural reference state
  int m_pc, m_page, m_sp;
  int m_stk[8];

  always #5 clk = ~clk;

  pc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .op_step(op_step),
    .op_jump(op_jump), .op_call(op_call), .op_ret(op_ret),
    .alu_wr_en(alu_wr_en), .alu_data(alu_data), .jmp_lit(jmp_lit),
    .page_we(page_we), .page_din(page_din), .fetch_addr(fetch_addr)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: fetch_addr=0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    irq_take = 0; op_step = 0; op_jump = 0; op_call = 0; op_ret = 0;
    alu_wr_en = 0; page_we = 0; alu_data = '0; jmp_lit = '0; page_din = '0;
  endtask

  task automatic m_push(int v);
    m_stk[m_sp] = v;
    m_sp = (m_sp + 1) % 8;
  endtask

  function automatic int m_pop();
    m_sp = (m_sp + 7) % 8;
    return m_stk[m_sp];
  endfunction

  // One clock: predict from the driven inputs, clock, compare, clear inputs.
  task automatic tick(string tag);
    int nxt, seq;
    seq = (m_pc + 1) % 8192;
    nxt = m_pc;
    if (irq_take)       begin m_push(seq); nxt = 4; end
    else if (op_ret)    nxt = m_pop();
    else if (op_call)   begin m_push(seq); nxt = (m_page / 8) * 2048 + int'(jmp_lit); end
    else if (op_jump)   nxt = (m_page / 8) * 2048 + int'(jmp_lit);
    else if (alu_wr_en) nxt = m_page * 256 + int'(alu_data);
    else if (op_step)   nxt = seq;
    if (page_we && !irq_take) m_page = int'(page_din);
    m_pc = nxt;
    @(posedge clk);
    #1;
    check(tag, int'(fetch_addr), m_pc);
    idle_inputs();
  endtask

  task automatic set_page(int p, string tag);
    page_we = 1; page_din = 5'(p); tick(tag);
  endtask

  initial begin
    #2ms;
    bad++; total++;
    $display("FAIL watchdog: fetch_addr=0x%04h expected run end", fetch_addr);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    idle_inputs();
    rst_n = 0;
    m_pc = 0; m_page = 0; m_sp = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", int'(fetch_addr), 0);
    rst_n = 1;
    tick("R1 idle after release");

    // R2 sequential steps
    for (int i = 0; i < 5; i++) begin op_step = 1; tick("R2 step"); end

    // R10 page write then jump; R3 jump target
    set_page(5'h0A, "R10 page write");
    op_jump = 1; jmp_lit = 11'h123; tick("R3 jump page 1");
    op_jump = 1; jmp_lit = 11'h7FF; page_we = 1; page_din = 5'h18;
    tick("R10 same-cycle page uses old value");
    op_jump = 1; jmp_lit = 11'h010; tick("R10 new page on later jump");

    // R6 ALU low byte write
    set_page(5'h0A, "R10 page write");
    alu_wr_en = 1; alu_data = 8'h5C; tick("R6 alu write");

    // R4/R5 nested calls and returns
    op_call = 1; jmp_lit = 11'h200; tick("R4 call 1");
    op_step = 1; tick("R2 step in sub");
    op_call = 1; jmp_lit = 11'h300; tick("R4 call 2");
    op_call = 1; jmp_lit = 11'h400; tick("R4 call 3");
    op_ret = 1; tick("R5 return 3");
    op_ret = 1; tick("R5 return 2");
    op_ret = 1; tick("R5 return 1");

    // R7 interrupt with a page write attempt in the same cycle
    irq_take = 1; page_we = 1; page_din = 5'h1F; tick("R7 irq vector");
    alu_wr_en = 1; alu_data = 8'h00; tick("R7 page kept after irq");
    op_ret = 1; tick("R7 return from irq");

    // R9 priority collisions
    irq_take = 1; op_ret = 1; op_call = 1; op_step = 1; tick("R9 irq beats all");
    op_ret = 1; op_call = 1; jmp_lit = 11'h055; tick("R9 ret beats call");
    op_call = 1; op_jump = 1; jmp_lit = 11'h066; tick("R9 call beats jump");
    op_jump = 1; alu_wr_en = 1; jmp_lit = 11'h077; alu_data = 8'hEE; tick("R9 jump beats alu");
    alu_wr_en = 1; op_step = 1; alu_data = 8'h33; tick("R9 alu beats step");
    tick("R9 hold with no strobe");
    op_ret = 1; tick("R9 return");

    // R8 ring wrap: nine calls, then eleven returns
    for (int i = 0; i < 9; i++) begin
      op_call = 1; jmp_lit = 11'(16 * i + 1); tick("R8 deep call");
    end
    for (int i = 0; i < 11; i++) begin op_ret = 1; tick("R8 return past ring"); end

    // R2 wrap at the top of memory
    set_page(5'h1F, "R10 page top");
    alu_wr_en = 1; alu_data = 8'hFF; tick("R6 alu to top");
    op_step = 1; tick("R2 wrap to zero");

    // Mixed pseudo-random strobes, compared every cycle
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      irq_take  = (lfsr[3:0] == 4'h0);
      op_ret    = (lfsr[6:4] == 3'h1);
      op_call   = (lfsr[6:4] == 3'h2);
      op_jump   = (lfsr[6:4] == 3'h3);
      alu_wr_en = (lfsr[9:7] == 3'h4);
      op_step   = lfsr[10];
      page_we   = (lfsr[13:11] == 3'h5);
      page_din  = lfsr[15:11];
      jmp_lit   = lfsr[10:0];
      alu_data  = lfsr[15:8];
      tick("R9 random mix");
    end

    // R1 reset again mid-run
    rst_n = 0;
    m_pc = 0; m_page = 0; m_sp = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    #3;
    check("R1 async reset", int'(fetch_addr), 0);
    @(posedge clk); #1;
    rst_n = 1;
    op_ret = 1; tick("R1 stack cleared by reset");
    alu_wr_en = 1; alu_data = 8'h12; tick("R1 page cleared by reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule